// File: doc/BRIEF.md
# Credit-Gated Virtual Output Queue Scheduler

This block queues packet descriptors between a set of ingress ports and a set of egress ports. Every ingress/egress pair has its own small queue, so a descriptor waits behind earlier traffic only if that traffic is bound for the same destination. A non-empty pair queue asks its destination for a credit. Each destination hands out a credit only when it has a free slot reserved for the descriptor. A descriptor crosses the crossbar only in the cycle after its queue has won a credit, and it then lands in the destination's output queue. The output queue is drained through a simple pop strobe.

Credit issue works like a single-iteration request/grant/accept match. Each destination grants one requesting ingress per cycle, chosen round-robin after the ingress it last served. Each ingress then accepts one of the grants it received, also round-robin. Only accepted grants become credits. A destination that is backed up therefore stops granting, and the ingress queues that target other destinations keep moving. Payload storage, header processing and multicast replication happen elsewhere.

Top module: `voq_credit_sched`

## Requirements
- R1: A descriptor offered on the enqueue port is taken at the clock edge when `enq_valid` and `enq_ready` are both high. `enq_ready` is low exactly when the pair queue selected by (`enq_src`, `enq_dst`) already holds VOQ_DEPTH descriptors.
- R2: `crd_req` bit `dst*N_IN+src` is high while pair queue (src,dst) holds more descriptors than it has credits for. It rises in the cycle after the first enqueue and stays high until a credit is issued.
- R3: An output queue never receives a descriptor while it is full. A credit for a destination is issued only when that destination's free slots exceed the credits it already has in flight.
- R4: `xb_valid[d]` is high in a cycle exactly when a credit for destination d was issued (`crd_gnt`) in the previous cycle. `xb_src` names the ingress that received that credit.
- R5: In each cycle, at most one credit is issued per destination and at most one per ingress. As a result, the crossbar carries at most one descriptor per destination and per ingress.
- R6: Suppose several ingresses keep requesting one destination and no other destination competes. Credits then go to them in round-robin order, starting with the ingress after the one last served.
- R7: When a destination's output queue is full and not drained, descriptors from the same ingress to other destinations still cross the crossbar with no added delay.
- R8: Descriptors of one (src,dst) pair leave the crossbar, and later the output queue, in arrival order, and none is lost or duplicated.
- R9: Suppose a descriptor is enqueued at edge E0 into an idle pair queue whose destination has room. Its credit is visible on `crd_gnt` in the following cycle, it is on the crossbar one cycle later, and it is presented on `oq_valid`/`oq_src`/`oq_len` one cycle after that.
- R10: `oq_deq[d]` removes the head of output queue d at the clock edge when `oq_valid[d]` is high. When the queue is empty it is ignored.
- R11: After reset, all valid, request and credit outputs are low and `enq_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Descriptor offered |
| enq_src | input | IW | Ingress id of the descriptor |
| enq_dst | input | OW | Egress id of the descriptor |
| enq_len | input | LEN_W | Descriptor length field |
| enq_ready | output | 1 | Selected pair queue has space |
| crd_req | output | N_IN*N_OUT | Credit requests, bit dst*N_IN+src |
| crd_gnt | output | N_IN*N_OUT | Credits issued this cycle, same indexing |
| xb_valid | output | N_OUT | Crossbar transfer into each egress |
| xb_src | output | N_OUT*IW | Ingress id per egress transfer (field d at d*IW) |
| xb_len | output | N_OUT*LEN_W | Length per egress transfer (field d at d*LEN_W) |
| oq_deq | input | N_OUT | Pop strobe per output queue |
| oq_valid | output | N_OUT | Output queue holds a descriptor |
| oq_src | output | N_OUT*IW | Ingress id at head of each output queue |
| oq_len | output | N_OUT*LEN_W | Length at head of each output queue |

## Verification
An enqueue sampled at one edge shows up on `crd_req` and, when room exists, on `crd_gnt` in the next cycle. The matching crossbar transfer follows one cycle after that, and the output-queue head one cycle after the transfer. The bench drives and samples on the falling edge. It keeps the credits it saw in one cycle and demands the matching transfers in the next, and it mirrors every pair queue and output queue so that each pop is compared with the head the model predicts. The directed congestion case checks credit, transfer and output head at exactly one, two and three cycles after the enqueue edge. The fairness case records the transfer order into one destination and compares it with the rotation computed from the last ingress served.

// File: rtl/voq_pkg.sv
package voq_pkg;

  // Next candidate index of a rotating search over n slots.
  function automatic int rr_index(int base, int step, int n);
    return (base + step) % n;
  endfunction

  // A credit may be issued while free slots exceed credits already in flight.
  function automatic logic room_for_credit(int depth, int used, int in_flight);
    return (depth - used) > in_flight;
  endfunction

  // Flat position of an (ingress, egress) pair.
  function automatic int pair_pos(int src, int dst, int n_in);
    return dst * n_in + src;
  endfunction

endpackage

// File: rtl/voq_fifo.sv
module voq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_e, pop_e;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign push_e = push && !full;
  assign pop_e  = pop && !empty;
  assign dout   = mem[rp];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_e) wp <= bump(wp);
      if (pop_e)  rp <= bump(rp);
      cnt <= cnt + CW'(push_e) - CW'(pop_e);
    end
  end

  always_ff @(posedge clk) begin
    if (push_e) mem[wp] <= din;
  end

  // R3: writers must never push into a full queue
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N   = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  import voq_pkg::*;

  logic [PW-1:0] last_q;
  logic [PW-1:0] sel;
  logic          found;

  always_comb begin
    gnt   = '0;
    sel   = last_q;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!found && req[PW'(rr_index(int'(last_q), k, N))]) begin
        gnt[PW'(rr_index(int'(last_q), k, N))] = 1'b1;
        sel   = PW'(rr_index(int'(last_q), k, N));
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              last_q <= PW'(N - 1);
    else if (adv && found)   last_q <= sel;
  end

  // R5: a single winner per cycle
  p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R6: the winner is always a requester, and some requester always wins
  p_winner_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_no_idle_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

endmodule

// File: rtl/voq_credit_sched.sv
module voq_credit_sched #(
  parameter int N_IN      = 4,
  parameter int N_OUT     = 4,
  parameter int VOQ_DEPTH = 4,
  parameter int OQ_DEPTH  = 4,
  parameter int LEN_W     = 8,
  localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OW  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int NP  = N_IN * N_OUT,
  localparam int VCW = $clog2(VOQ_DEPTH + 1),
  localparam int OCW = $clog2(OQ_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enq_valid,
  input  logic [IW-1:0]          enq_src,
  input  logic [OW-1:0]          enq_dst,
  input  logic [LEN_W-1:0]       enq_len,
  output logic                   enq_ready,
  output logic [NP-1:0]          crd_req,
  output logic [NP-1:0]          crd_gnt,
  output logic [N_OUT-1:0]       xb_valid,
  output logic [N_OUT*IW-1:0]    xb_src,
  output logic [N_OUT*LEN_W-1:0] xb_len,
  input  logic [N_OUT-1:0]       oq_deq,
  output logic [N_OUT-1:0]       oq_valid,
  output logic [N_OUT*IW-1:0]    oq_src,
  output logic [N_OUT*LEN_W-1:0] oq_len
);
  import voq_pkg::*;

  // Pair-indexed state, bit p = dst*N_IN + src
  logic [NP-1:0]    voq_push, voq_full, voq_empty;
  logic [LEN_W-1:0] voq_head [NP];
  logic [VCW-1:0]   voq_cnt  [NP];
  logic [NP-1:0]    cred_q;      // credit held, descriptor crosses this cycle
  logic [NP-1:0]    req;         // pair queue wants a credit
  logic [NP-1:0]    ogrant;      // egress-side grant
  logic [NP-1:0]    accept;      // ingress-side acceptance, becomes a credit
  // Transposed views, bit t = src*N_OUT + dst
  logic [NP-1:0]    ogrant_t, accept_t;

  logic [N_OUT-1:0] room;
  logic [N_OUT-1:0] oq_full, oq_empty;
  logic [OCW-1:0]   oq_cnt [N_OUT];

  // ---------------- pair queues ----------------
  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_dst
      for (genvar i = 0; i < N_IN; i++) begin : g_src
        localparam int P = o * N_IN + i;

        assign voq_push[P] = enq_valid && (enq_src == IW'(i)) &&
                             (enq_dst == OW'(o)) && !voq_full[P];
        assign req[P]      = voq_cnt[P] > VCW'(cred_q[P]);
        assign ogrant_t[i*N_OUT+o] = ogrant[P];
        assign accept[P]           = accept_t[i*N_OUT+o];

        voq_fifo #(.W(LEN_W), .DEPTH(VOQ_DEPTH)) u_voq (
          .clk   (clk),
          .rst_n (rst_n),
          .push  (voq_push[P]),
          .din   (enq_len),
          .pop   (cred_q[P]),
          .dout  (voq_head[P]),
          .cnt   (voq_cnt[P]),
          .full  (voq_full[P]),
          .empty (voq_empty[P])
        );

        // R2: a pending request stays up until it is turned into a credit
        p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
          (req[P] && !accept[P]) |=> req[P]);
        // R4: a credited queue always has a descriptor to send
        p_credit_covers_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
          cred_q[P] |-> !voq_empty[P]);
      end
    end
  endgenerate

  always_comb begin
    enq_ready = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (enq_src == IW'(p % N_IN) && enq_dst == OW'(p / N_IN))
        enq_ready = !voq_full[p];
    end
  end

  // ---------------- egress grant stage ----------------
  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_grant
      logic [N_IN-1:0] col_req;

      assign room[o]  = room_for_credit(OQ_DEPTH, int'(oq_cnt[o]),
                                        $countones(cred_q[o*N_IN +: N_IN]));
      assign col_req  = req[o*N_IN +: N_IN] & {N_IN{room[o]}};

      rr_arbiter #(.N(N_IN)) u_out_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (col_req),
        .adv   (|accept[o*N_IN +: N_IN]),
        .gnt   (ogrant[o*N_IN +: N_IN])
      );

      // R5: one credit per destination per cycle
      p_one_credit_per_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept[o*N_IN +: N_IN]));
    end
  endgenerate

  // ---------------- ingress accept stage ----------------
  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_accept
      rr_arbiter #(.N(N_OUT)) u_in_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ogrant_t[i*N_OUT +: N_OUT]),
        .adv   (|ogrant_t[i*N_OUT +: N_OUT]),
        .gnt   (accept_t[i*N_OUT +: N_OUT])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cred_q <= '0;
    else        cred_q <= accept;
  end

  assign crd_req = req;
  assign crd_gnt = accept;

  // ---------------- crossbar and output queues ----------------
  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_oq
      logic [IW-1:0]    sel_src;
      logic [LEN_W-1:0] sel_len;

      always_comb begin
        sel_src = '0;
        sel_len = '0;
        for (int i = 0; i < N_IN; i++) begin
          if (cred_q[o*N_IN + i]) begin
            sel_src = IW'(i);
            sel_len = voq_head[o*N_IN + i];
          end
        end
      end

      assign xb_valid[o]               = |cred_q[o*N_IN +: N_IN];
      assign xb_src[o*IW +: IW]        = sel_src;
      assign xb_len[o*LEN_W +: LEN_W]  = sel_len;
      assign oq_valid[o]               = !oq_empty[o];

      voq_fifo #(.W(IW + LEN_W), .DEPTH(OQ_DEPTH)) u_oq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (xb_valid[o]),
        .din   ({sel_src, sel_len}),
        .pop   (oq_deq[o]),
        .dout  ({oq_src[o*IW +: IW], oq_len[o*LEN_W +: LEN_W]}),
        .cnt   (oq_cnt[o]),
        .full  (oq_full[o]),
        .empty (oq_empty[o])
      );

      // R3: reservation means a crossing descriptor always finds a slot
      p_oq_has_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid[o] |-> !oq_full[o]);
      // R4: every crossing follows a credit issued in the previous cycle
      p_xfer_after_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid[o] |-> $past(|accept[o*N_IN +: N_IN]));
    end
  endgenerate

endmodule

// File: tb/voq_credit_sched_tb.sv
module voq_credit_sched_tb;
  localparam int N_IN = 4, N_OUT = 4, VOQ_DEPTH = 4, OQ_DEPTH = 4, LW = 8;
  localparam int IW = 2, OW = 2, NP = N_IN * N_OUT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_ready;
  logic [IW-1:0] enq_src = '0;
  logic [OW-1:0] enq_dst = '0;
  logic [LW-1:0] enq_len = '0;
  logic [NP-1:0] crd_req, crd_gnt;
  logic [N_OUT-1:0] xb_valid, oq_valid;
  logic [N_OUT-1:0] oq_deq = '0;
  logic [N_OUT*IW-1:0] xb_src, oq_src;
  logic [N_OUT*LW-1:0] xb_len, oq_len;

  always #10 clk = ~clk;  // 50 MHz

  voq_credit_sched u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_src(enq_src),
    .enq_dst(enq_dst), .enq_len(enq_len), .enq_ready(enq_ready),
    .crd_req(crd_req), .crd_gnt(crd_gnt), .xb_valid(xb_valid), .xb_src(xb_src),
    .xb_len(xb_len), .oq_deq(oq_deq), .oq_valid(oq_valid), .oq_src(oq_src),
    .oq_len(oq_len)
  );

  int n_chk = 0, n_fail = 0;
  int pair_q [NP][$];
  int oq_q   [N_OUT][$];
  int seq_q  [$];
  logic [NP-1:0] prev_gnt = '0;
  bit in_reset = 1'b1, log_en = 1'b0;

  task automatic chk(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int pos(int s, int d);
    return d * N_IN + s;
  endfunction

  function automatic int pack(int s, int l);
    return s * 256 + l;
  endfunction

  // Post-edge checks against the bench model
  task automatic monitor();
    if (in_reset) return;
    for (int o = 0; o < N_OUT; o++) begin
      chk(oq_valid[o] == (oq_q[o].size() != 0), "R10", oq_valid[o], oq_q[o].size() != 0);
      chk(oq_q[o].size() <= OQ_DEPTH, "R3", oq_q[o].size(), OQ_DEPTH);
      chk($countones(crd_gnt[o*N_IN +: N_IN]) <= 1, "R5", $countones(crd_gnt[o*N_IN +: N_IN]), 1);
      chk(xb_valid[o] == (|prev_gnt[o*N_IN +: N_IN]), "R4", xb_valid[o], |prev_gnt[o*N_IN +: N_IN]);
      if (xb_valid[o]) begin
        int s, l, e;
        s = int'(xb_src[o*IW +: IW]);
        l = int'(xb_len[o*LW +: LW]);
        chk(prev_gnt[pos(s, o)], "R4", s, o);
        if (pair_q[pos(s, o)].size() == 0) chk(1'b0, "R8", l, -1);
        else begin
          e = pair_q[pos(s, o)].pop_front();
          chk(l == e, "R8", l, e);
        end
        oq_q[o].push_back(pack(s, l));
        if (log_en && o == 2) seq_q.push_back(s);
      end
    end
    for (int i = 0; i < N_IN; i++) begin
      int c = 0;
      for (int o = 0; o < N_OUT; o++) c += int'(crd_gnt[pos(i, o)]);
      chk(c <= 1, "R5", c, 1);
    end
    prev_gnt = crd_gnt;
  endtask

  // One clock: record what the edge will take, then check after it
  task automatic tick();
    #1;
    if (!in_reset) begin
      if (enq_valid && enq_ready)
        pair_q[pos(int'(enq_src), int'(enq_dst))].push_back(int'(enq_len));
      for (int o = 0; o < N_OUT; o++) begin
        if (oq_deq[o] && oq_valid[o]) begin
          int e, a;
          e = oq_q[o].pop_front();
          a = pack(int'(oq_src[o*IW +: IW]), int'(oq_len[o*LW +: LW]));
          chk(a == e, "R10", a, e);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    monitor();
  endtask

  task automatic do_reset();
    in_reset = 1'b1;
    rst_n = 1'b0; enq_valid = 1'b0; oq_deq = '0;
    tick(); tick();
    for (int p = 0; p < NP; p++) pair_q[p].delete();
    for (int o = 0; o < N_OUT; o++) oq_q[o].delete();
    prev_gnt = '0;
    rst_n = 1'b1;
    in_reset = 1'b0;
  endtask

  task automatic put(int s, int d, int l);
    enq_valid = 1'b1; enq_src = IW'(s); enq_dst = OW'(d); enq_len = LW'(l);
    tick();
    enq_valid = 1'b0;
  endtask

  task automatic drain_check();
    int left = 0;
    enq_valid = 1'b0; oq_deq = '1;
    for (int k = 0; k < 60; k++) tick();
    for (int p = 0; p < NP; p++) left += pair_q[p].size();
    for (int o = 0; o < N_OUT; o++) left += oq_q[o].size();
    chk(left == 0, "R8", left, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    do_reset();
    tick();
    // R11: reset state
    chk(enq_ready == 1'b1, "R11", enq_ready, 1);
    chk(crd_req == '0 && crd_gnt == '0, "R11", int'(crd_req | crd_gnt), 0);
    chk(xb_valid == '0 && oq_valid == '0, "R11", int'(xb_valid | oq_valid), 0);

    // R10: popping empty queues has no effect
    oq_deq = '1;
    for (int k = 0; k < 3; k++) tick();
    chk(oq_valid == '0, "R10", int'(oq_valid), 0);

    // R7/R1/R9: congest egress 1, then send from ingress 0 to egress 3
    oq_deq = 4'b1101;
    for (int k = 0; k < 4; k++) put(2, 1, 16 + k);
    for (int k = 0; k < 4; k++) put(0, 1, 32 + k);
    for (int k = 0; k < 3; k++) tick();
    enq_valid = 1'b1; enq_src = 2'd0; enq_dst = 2'd1; enq_len = 8'd99;
    #1 chk(enq_ready == 1'b0, "R1", enq_ready, 0);
    enq_dst = 2'd3; enq_len = 8'd77;
    #1 chk(enq_ready == 1'b1, "R1", enq_ready, 1);
    tick();                     // edge E0 takes the descriptor
    enq_valid = 1'b0;
    chk(crd_req[pos(0, 3)] == 1'b1, "R2", crd_req[pos(0, 3)], 1);
    chk(crd_gnt[pos(0, 3)] == 1'b1, "R9", crd_gnt[pos(0, 3)], 1);
    tick();
    chk(xb_valid[3] == 1'b1 && xb_src[3*IW +: IW] == 2'd0, "R7", int'(xb_valid[3]), 1);
    chk(xb_valid[1] == 1'b0, "R7", xb_valid[1], 0);
    tick();
    chk(oq_valid[3] == 1'b1 && oq_len[3*LW +: LW] == 8'd77, "R9", int'(oq_len[3*LW +: LW]), 77);
    drain_check();

    // R6: four ingresses contend for egress 2 after ingress 0 was served last
    do_reset();
    oq_deq = 4'b1011;
    for (int k = 0; k < 4; k++) put(0, 2, k);
    for (int k = 0; k < 3; k++) tick();
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < N_IN; s++) put(s, 2, 64 + r * 4 + s);
    tick();
    log_en = 1'b1;
    oq_deq = '1;
    for (int k = 0; k < 30; k++) tick();
    log_en = 1'b0;
    chk(seq_q.size() == 8, "R6", seq_q.size(), 8);
    for (int k = 0; k < 8 && k < seq_q.size(); k++)
      chk(seq_q[k] == (k + 1) % N_IN, "R6", seq_q[k], (k + 1) % N_IN);
    drain_check();

    // Random traffic, egress 0 drained rarely
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      enq_valid = ($urandom % 4) != 0;
      enq_src   = IW'($urandom);
      enq_dst   = OW'($urandom);
      enq_len   = LW'($urandom);
      oq_deq[0] = ($urandom % 8) == 0;
      for (int o = 1; o < N_OUT; o++) oq_deq[o] = ($urandom % 8) < 5;
      tick();
    end
    drain_check();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule